// File: doc/BRIEF.md
# Quantized-Analog Refresh Sequencer

This block supplies the digital timing for a refresh scheme in which many analog storage nodes share one stepped ramp. A global part produces an unsigned binary staircase code that an external stepped-ramp generator turns into a voltage. The code climbs one level per period of a slow derived clock. Each period is split into a high half and a low half of `HALF_CYC` system cycles. The code changes only at the start of a high half and stays flat through the low half.

Each cell has its own comparator, which raises a flag when the ramp is above the value held on that cell's node. The flag is asynchronous. The cell synchronizes it and captures the first trip in a sweep. It then closes a copy switch for the next low half, which loads the flat ramp level onto the node. In the high half right after that it pulses a discharge source, which removes half a step.

Because of this, a value that drifted up or down by less than half a step comes back to the same level on every sweep. The sweep starts with a reset period at level zero, then steps through every level, then holds the top level for one extra period so that a trip at the top level can still finish its discharge. After that the code returns to zero. The sweep runs the same way whatever the cells are doing.

Top module: `qa_refresh_seq`

## Requirements
- R1: For levels 1 up to 2^LEVEL_W-1, `level_o` rises by exactly one at the first cycle of a high half and holds for the whole period of 2*HALF_CYC cycles, which is a high half followed by a low half.
- R2: A sweep lasts (2^LEVEL_W+1)*2*HALF_CYC cycles. It starts with one reset period at level 0, then covers levels 1 to 2^LEVEL_W-1 in turn, then holds the top level for one tail period. Then the code returns to 0. The comparator inputs have no effect on this.
- R3: While `rst_ni` is low, `level_o` is 0 and every copy and discharge enable is 0. The first cycle after release is the first cycle of the high half of the reset period.
- R4: A `cmp_i` bit of 1 means the level is above the stored value. The flag is synchronized, and `SYNC_STAGES` must not exceed HALF_CYC-1. Suppose a cell's flag first becomes 1 within a sweep during the high half of level L, or was already 1 at the start of it. The cell's `copy_en_o` bit is then 1 for exactly the whole low half of level L.
- R5: The cell's `sub_en_o` bit is 1 for exactly the whole high half that directly follows its copy half, and at no other time.
- R6: A cell issues at most one copy/discharge pair per sweep, and later flag activity is ignored until the next reset period. A cell whose flag stays 0 through levels 1 to 2^LEVEL_W-1 issues no pulse in that sweep.
- R7: No enable is 1 during the reset period. A flag that becomes 1 only during the tail period or the reset period starts no pulse. Copy and discharge of the same cell are never 1 together.
- R8: The `N_CELLS` cells run in parallel. Each cell's enables depend only on its own `cmp_i` bit and on the shared staircase.
- R9: Take a node whose value sits on the refreshed grid (L minus half a step). If it drifts by less than half a step in either direction between sweeps, it is restored to exactly its previous value.
- R10: A newly written value inside the ramp range is refreshed to the first level above it, minus half a step. This is within one step of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one half of the derived period lasts HALF_CYC cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | N_CELLS | Asynchronous comparator flags; 1 = ramp above stored value |
| level_o | output | LEVEL_W | Staircase level code to the stepped-ramp generator |
| copy_en_o | output | N_CELLS | Per-cell switch that copies the ramp level onto the node |
| sub_en_o | output | N_CELLS | Per-cell pulse that removes half a step from the node |

## Verification
The bench models each node as an integer in quarter-step units, and it drives each flag from that model and the level code. Directed values test the ends of the range: zero, which trips at level 1; the highest value that still trips, which puts the discharge into the tail period; and a value above the ramp, which must produce no pulse. A value lowered during the tail period must also be ignored. Directed and random drifts of plus or minus one quarter step, each applied to a refreshed value, tell exact restoration apart from an off-by-one copy level or a discharge that is missing or repeated. Random new writes across the range exercise the one-step bound and check the copy and discharge timing cycle by cycle at many different trip levels.

// File: rtl/qa_refresh_pkg.sv
package qa_refresh_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_ARMED,
    CS_COPY,
    CS_SUB,
    CS_DONE
  } cell_st_e;

endpackage

// File: rtl/qa_stair_gen.sv
module qa_stair_gen #(
  parameter int unsigned LEVEL_W  = 8,
  parameter int unsigned HALF_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [LEVEL_W-1:0] level_o,
  output logic               hi_o,
  output logic               half_end_o,
  output logic               sweep_rst_o,
  output logic               capture_en_o
);

  localparam int unsigned NLEV  = 1 << LEVEL_W;
  localparam int unsigned PER_W = LEVEL_W + 1;
  localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [PER_W-1:0] PER_TAIL = PER_W'(NLEV);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic               hi_q;
  logic [PER_W-1:0]   per_q, per_nxt;
  logic [LEVEL_W-1:0] level_q;
  logic               half_end;

  // tail period repeats the top level so a top-level trip can finish its discharge
  function automatic logic [LEVEL_W-1:0] lvl_of(input logic [PER_W-1:0] p);
    if (p == PER_TAIL) return {LEVEL_W{1'b1}};
    return p[LEVEL_W-1:0];
  endfunction

  assign half_end = (cnt_q == CNT_LAST);
  assign per_nxt  = (per_q == PER_TAIL) ? '0 : per_q + PER_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      hi_q    <= 1'b1;
      per_q   <= '0;
      level_q <= '0;
    end else if (half_end) begin
      cnt_q <= '0;
      hi_q  <= ~hi_q;
      if (!hi_q) begin
        per_q   <= per_nxt;
        level_q <= lvl_of(per_nxt);
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign level_o      = level_q;
  assign hi_o         = hi_q;
  assign half_end_o   = half_end;
  assign sweep_rst_o  = (per_q == '0);
  assign capture_en_o = (per_q != '0) && (per_q != PER_TAIL);

endmodule

// File: rtl/qa_sync.sv
module qa_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/qa_cell_seq.sv
module qa_cell_seq
  import qa_refresh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic hi_i,
  input  logic half_end_i,
  input  logic sweep_rst_i,
  input  logic capture_en_i,
  output logic copy_en_o,
  output logic sub_en_o
);

  cell_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (sweep_rst_i) begin
      st_d = CS_IDLE;
    end else begin
      unique case (st_q)
        CS_IDLE: begin
          if (trip_i && capture_en_i)
            st_d = (hi_i && half_end_i) ? CS_COPY : CS_ARMED;
        end
        CS_ARMED: begin
          // a late capture in the last window is dropped rather than split by the reset
          if (hi_i && half_end_i) st_d = capture_en_i ? CS_COPY : CS_IDLE;
        end
        CS_COPY:  if (half_end_i) st_d = CS_SUB;
        CS_SUB:   if (half_end_i) st_d = CS_DONE;
        CS_DONE:  st_d = CS_DONE;
        default:  st_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CS_IDLE;
    else         st_q <= st_d;
  end

  assign copy_en_o = (st_q == CS_COPY);
  assign sub_en_o  = (st_q == CS_SUB);

endmodule

// File: rtl/qa_refresh_seq.sv
module qa_refresh_seq #(
  parameter int unsigned N_CELLS     = 4,
  parameter int unsigned LEVEL_W     = 8,
  parameter int unsigned HALF_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CELLS-1:0] cmp_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic [N_CELLS-1:0] copy_en_o,
  output logic [N_CELLS-1:0] sub_en_o
);

  logic hi, half_end, sweep_rst, capture_en;

  qa_stair_gen #(
    .LEVEL_W (LEVEL_W),
    .HALF_CYC(HALF_CYC)
  ) u_stair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_o     (level_o),
    .hi_o        (hi),
    .half_end_o  (half_end),
    .sweep_rst_o (sweep_rst),
    .capture_en_o(capture_en)
  );

  generate
    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
      logic trip;

      qa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (cmp_i[g]),
        .q_o   (trip)
      );

      qa_cell_seq u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trip_i      (trip),
        .hi_i        (hi),
        .half_end_i  (half_end),
        .sweep_rst_i (sweep_rst),
        .capture_en_i(capture_en),
        .copy_en_o   (copy_en_o[g]),
        .sub_en_o    (sub_en_o[g])
      );
    end
  endgenerate

endmodule

// File: rtl/qa_refresh_chk.sv
module qa_refresh_chk #(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned LEVEL_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [LEVEL_W-1:0] level_i,
  input logic [N_CELLS-1:0] copy_en_i,
  input logic [N_CELLS-1:0] sub_en_i
);

  localparam logic [LEVEL_W-1:0] LVL_MAX = {LEVEL_W{1'b1}};

  p_level_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != $past(level_i)) |-> (level_i == $past(level_i) + LEVEL_W'(1)) || (level_i == '0));

  p_wrap_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0 && $past(level_i) != '0) |-> ($past(level_i) == LVL_MAX));

  generate
    for (genvar g = 0; g < N_CELLS; g++) begin : g_c
      logic copy_d, seen_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          copy_d <= 1'b0;
          seen_q <= 1'b0;
        end else begin
          copy_d <= copy_en_i[g];
          if (level_i == '0)                    seen_q <= 1'b0;
          else if (copy_en_i[g] && !copy_d)     seen_q <= 1'b1;
        end
      end

      p_copy_flat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (copy_en_i[g] && $past(copy_en_i[g])) |-> $stable(level_i));

      p_sub_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(copy_en_i[g]) |-> sub_en_i[g]);

      p_sub_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sub_en_i[g]) |-> $past(copy_en_i[g]));

      p_one_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(copy_en_i[g]) |-> !seen_q);

      p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(copy_en_i[g] && sub_en_i[g]));

      p_quiet_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_i == '0) |-> !(copy_en_i[g] || sub_en_i[g]));
    end
  endgenerate

endmodule

bind qa_refresh_seq qa_refresh_chk #(
  .N_CELLS(N_CELLS),
  .LEVEL_W(LEVEL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .level_i  (level_o),
  .copy_en_i(copy_en_o),
  .sub_en_i (sub_en_o)
);

// File: tb/sim_qa_refresh_seq.sv
module sim_qa_refresh_seq;

  localparam int N_CELLS   = 4;
  localparam int LEVEL_W   = 8;
  localparam int HALF_CYC  = 4;
  localparam int NLEV      = 1 << LEVEL_W;
  localparam int SWEEP_CYC = (NLEV + 1) * 2 * HALF_CYC;
  localparam int SWEEPS    = 14;
  localparam int TOP_TRIP  = 4 * (NLEV - 1) - 1;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [N_CELLS-1:0] cmp;
  logic [LEVEL_W-1:0] level;
  logic [N_CELLS-1:0] copy_en, sub_en;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;
  int unsigned c = 0;

  // node model in quarter-step units
  int stored  [N_CELLS];
  int lexp    [N_CELLS];
  int res_exp [N_CELLS];
  int wr_val  [N_CELLS];
  int prev_val[N_CELLS];
  bit wr_mode [N_CELLS];
  bit grid_prev[N_CELLS];
  bit sub_prev[N_CELLS];

  always #4 clk = ~clk;

  qa_refresh_seq #(
    .N_CELLS(N_CELLS), .LEVEL_W(LEVEL_W), .HALF_CYC(HALF_CYC), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp),
    .level_o(level), .copy_en_o(copy_en), .sub_en_o(sub_en)
  );

  always_comb begin
    for (int q = 0; q < N_CELLS; q++) cmp[q] = (4 * int'(level)) > stored[q];
  end

  always @(posedge clk) begin
    if (!rst_n) c <= 0;
    else        c <= c + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, c, act, exp);
    end
  endtask

  function automatic int trip_lvl(input int s);
    if (s > TOP_TRIP) return 0;
    if (s < 0) return 1;
    return s / 4 + 1;
  endfunction

  function automatic int exp_level(input int unsigned cyc);
    int unsigned per;
    per = ((cyc / HALF_CYC) % (2 * (NLEV + 1))) / 2;
    if (per == NLEV) return NLEV - 1;
    return int'(per);
  endfunction

  task automatic plan_sweep(input int s);
    for (int q = 0; q < N_CELLS; q++) begin
      bit wr;
      int v, d;
      grid_prev[q] = (s > 0) && (lexp[q] != 0);
      prev_val[q]  = stored[q];
      wr = 1'b0; v = 0; d = 0;
      if (s == 0) begin
        wr = 1'b1;
        case (q % 4)
          0: v = 0;
          1: v = TOP_TRIP;
          2: v = TOP_TRIP + 11;
          default: v = 517;
        endcase
      end else if (s == 1) begin
        d = (q % 2 == 0) ? 1 : -1;
      end else if (s == 2 && q == 0) begin
        wr = 1'b1; v = 1100;
      end else if (s >= 3 && ($urandom % 3) == 0) begin
        wr = 1'b1; v = int'($urandom % 1024);
      end else begin
        d = int'($urandom % 3) - 1;
      end
      if (wr) stored[q] = v;
      else    stored[q] = stored[q] + d;
      wr_mode[q] = wr;
      wr_val[q]  = v;
      lexp[q]    = trip_lvl(stored[q]);
      res_exp[q] = (lexp[q] != 0) ? 4 * lexp[q] - 2 : stored[q];
    end
  endtask

  task automatic check_sweep();
    for (int q = 0; q < N_CELLS; q++) begin
      chk(stored[q] == res_exp[q], wr_mode[q] ? "R10" : "R9", stored[q], res_exp[q]);
      if (!wr_mode[q] && grid_prev[q])
        chk(stored[q] == prev_val[q], "R9", stored[q], prev_val[q]);
      if (wr_mode[q] && wr_val[q] >= 0 && wr_val[q] <= TOP_TRIP)
        chk((stored[q] - wr_val[q] <= 4) && (wr_val[q] - stored[q] <= 4), "R10",
            stored[q] - wr_val[q], 4);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      int unsigned hs, off;
      int el;
      hs  = (c / HALF_CYC) % (2 * (NLEV + 1));
      off = c % SWEEP_CYC;
      el  = exp_level(c);
      chk(int'(level) == el, (hs >= 2 && hs < 2 * NLEV) ? "R1" : "R2", int'(level), el);

      if (off == 0 && c != 0) begin
        check_sweep();
        plan_sweep(int'(c / SWEEP_CYC));
      end
      // flag rises only in the tail window for cell 0 on sweep 2
      if ((c / SWEEP_CYC) == 2 && off == unsigned'(2 * NLEV * HALF_CYC)) begin
        stored[0]  = 0;
        res_exp[0] = 0;
      end

      for (int q = 0; q < N_CELLS; q++) begin
        bit ec, es;
        ec = (lexp[q] != 0) && (hs == unsigned'(2 * lexp[q] + 1));
        es = (lexp[q] != 0) && (hs == unsigned'(2 * lexp[q] + 2));
        if (lexp[q] == 0)
          chk(!copy_en[q] && !sub_en[q], ((c / SWEEP_CYC) == 2 && q == 0) ? "R7" : "R6",
              int'({copy_en[q], sub_en[q]}), 0);
        else begin
          chk(copy_en[q] == ec, "R4 R8", int'(copy_en[q]), int'(ec));
          chk(sub_en[q] == es, "R5", int'(sub_en[q]), int'(es));
        end
        if (hs < 2) chk(!copy_en[q] && !sub_en[q], "R7", int'({copy_en[q], sub_en[q]}), 0);
        if (copy_en[q] && sub_en[q]) chk(1'b0, "R7", 3, 0);
        // node model updates
        if (copy_en[q]) stored[q] = 4 * int'(level);
        if (sub_en[q] && !sub_prev[q]) stored[q] = stored[q] - 2;
        sub_prev[q] = sub_en[q];
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    for (int q = 0; q < N_CELLS; q++) begin
      stored[q] = 0; lexp[q] = 0; sub_prev[q] = 1'b0;
    end
    plan_sweep(0);
    repeat (4) begin
      @(negedge clk);
      chk(level == '0, "R3", int'(level), 0);
      chk(copy_en == '0 && sub_en == '0, "R3", int'({copy_en, sub_en}), 0);
    end
    #1;
    rst_n = 1'b1;
    run   = 1'b1;
    repeat (SWEEPS * SWEEP_CYC + 2) @(posedge clk);
    run = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog cycle %0d actual 0 expected 1", c);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule